// File: doc/BRIEF.md
# EDO DRAM access sequencer

This block is a synchronous controller that sits between a simple host request port and a 4M x16 asynchronous DRAM with extended-data-out page mode. Each host request carries a read/write flag, a linear word address, two byte enables and write data. The controller splits the address into a row part and a column part. It activates the row, strobes the upper and lower byte lanes with their own column strobes, and returns read data with a one-cycle valid pulse. Every DRAM delay is an integer count of controller clock cycles, set by a parameter.

Once a row is activated it stays open. A later request to the same row runs as a short page cycle, with no new activation, provided the row has not been open longer than the page limit. A request to any other row first closes the row and waits out the precharge time. Writes are always issued as early writes: the write strobe falls one cycle before the column strobes, so the DRAM never drives the data bus during a write.

An external refresh arbiter can take the DRAM away from the controller by raising a grant. While the grant is high the controller accepts no requests and closes any open row.

Top module: `edo_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the row strobe, both column strobes, the write strobe and the output enable are high (inactive), the data driver is off, and ack and read-valid are low.
- R2: The host address is split with the column in bits [COL_W-1:0] and the row in bits [COL_W+ROW_W-1:COL_W]. The row appears on the DRAM address bus while the row strobe falls. The column, zero-extended, is driven from one cycle before the column strobes fall until the strobes rise.
- R3: A request accepted from idle makes the row strobe fall on the next cycle. The column strobes fall T_RCD+1 cycles after the row strobe falls.
- R4: Host byte-enable bit 1 selects the upper lane (data bits 15:8, upper column strobe) and bit 0 selects the lower lane (bits 7:0, lower column strobe). A lane's strobe falls only when its enable bit is set, and only while the row strobe is low.
- R5: On a write, the write strobe falls one cycle before the column strobes and stays low until they rise. The data driver is enabled, with the host write data, over that whole span, and the output enable stays high.
- R6: On a read, the output enable is low while the column strobes are low and the data driver is off. The data bus is sampled at the end of the last strobe-low cycle, and it is returned on the read data port together with a read-valid pulse lasting exactly one cycle.
- R7: The column strobes stay low for max(T_CAC, T_RAC-T_RCD-1) cycles on the first access after an activation, and for max(T_CAC, T_AA-1) cycles on a page hit.
- R8: After the strobes rise, a request to the open row is acknowledged once the strobes have been high for T_CP cycles. It starts a page cycle with no new row activation.
- R9: A request to a different row is not acknowledged while a row is open. The row strobe rises, and stays high for at least T_RP cycles, before the next activation.
- R10: When the open row has been active for PAGE_LIMIT cycles and the controller is between accesses, the row is closed with no host request.
- R11: While the refresh grant is high, ack stays low, an open row is closed between accesses, and no new row is activated.
- R12: Ack is high only in a cycle where the request is taken, and each ack starts exactly one DRAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request valid, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, row above column |
| host_be | input | 2 | Byte enables, bit 1 upper lane |
| host_wdata | input | DQ_W | Write data |
| host_ack | output | 1 | Request taken this cycle |
| host_rvalid | output | 1 | One-cycle read data valid |
| host_rdata | output | DQ_W | Read data |
| refresh_grant | input | 1 | External refresh owns the DRAM |
| dr_ras_n | output | 1 | Row strobe, active low |
| dr_ucas_n | output | 1 | Upper lane column strobe, active low |
| dr_lcas_n | output | 1 | Lower lane column strobe, active low |
| dr_we_n | output | 1 | Write strobe, active low |
| dr_oe_n | output | 1 | Output enable, active low |
| dr_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dr_dq_out | output | DQ_W | Data to the DRAM bus |
| dr_dq_oe | output | 1 | Drive enable for dr_dq_out |
| dr_dq_in | input | DQ_W | Data from the DRAM bus |

## Verification
The assertions watch the pin-level rules on every cycle. Column strobes appear only inside a row-strobe-low period, the write strobe is settled before a column strobe falls, and the data driver and output enable never conflict. Precharge length and the maximum row-low time are measured by counters. Read-valid lasts one cycle, and no ack is given during a refresh grant. Only the bench scenarios can show the sequences that depend on request history: which row is open, the difference between first-access and page-hit strobe lengths, which byte lane is written and what data comes back, and the row closing after the page limit. A reference model compares every pin each cycle and a behavioural DRAM checks the data.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, strobes high
        ST_ACT,    // row strobe low, row address held
        ST_COL,    // column address and write strobe set up
        ST_CAS,    // column strobes low
        ST_OPEN,   // row open, column strobes high
        ST_PRE     // row strobe high, precharge wait
    } seq_state_e;

endpackage

// File: rtl/edo_seq_addr.sv
module edo_seq_addr #(
    parameter int ROW_W = 13,
    parameter int COL_W = 9,
    parameter int AW    = 13
) (
    input  logic [ROW_W+COL_W-1:0] haddr_i,
    output logic [ROW_W-1:0]       row_o,
    output logic [AW-1:0]          row_bus_o,
    output logic [AW-1:0]          col_bus_o
);

    // Column occupies the low bits, row the bits above it.
    assign row_o     = haddr_i[COL_W +: ROW_W];
    assign row_bus_o = AW'(haddr_i[COL_W +: ROW_W]);
    assign col_bus_o = AW'(haddr_i[COL_W-1:0]);

endmodule

// File: rtl/edo_seq_page.sv
module edo_seq_page #(
    parameter int ROW_W = 13,
    parameter int LIMIT = 9900
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             hit_o,
    output logic             expired_o
);

    localparam int AGE_W = $clog2(LIMIT + 1);

    logic             valid_d, valid_q;
    logic [ROW_W-1:0] row_d,   row_q;
    logic [AGE_W-1:0] age_d,   age_q;

    always_comb begin
        valid_d = valid_q;
        row_d   = row_q;
        age_d   = age_q;
        if (open_i) begin
            valid_d = 1'b1;
            row_d   = row_i;
            age_d   = '0;
        end else begin
            if (close_i) begin
                valid_d = 1'b0;
            end
            if (valid_q && (age_q != AGE_W'(LIMIT))) begin
                age_d = age_q + AGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
            age_q   <= '0;
        end else begin
            valid_q <= valid_d;
            row_q   <= row_d;
            age_q   <= age_d;
        end
    end

    assign hit_o     = valid_q && (row_q == row_i);
    assign expired_o = valid_q && (age_q == AGE_W'(LIMIT));

endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 9,
    parameter int DQ_W       = 16,
    parameter int T_RCD      = 2,
    parameter int T_RAC      = 6,
    parameter int T_CAC      = 2,
    parameter int T_AA       = 3,
    parameter int T_CP       = 1,
    parameter int T_RP       = 4,
    parameter int PAGE_LIMIT = 9900
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [1:0]             host_be,
    input  logic [DQ_W-1:0]        host_wdata,
    output logic                   host_ack,
    output logic                   host_rvalid,
    output logic [DQ_W-1:0]        host_rdata,
    input  logic                   refresh_grant,
    output logic                   dr_ras_n,
    output logic                   dr_ucas_n,
    output logic                   dr_lcas_n,
    output logic                   dr_we_n,
    output logic                   dr_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dr_addr,
    output logic [DQ_W-1:0]        dr_dq_out,
    output logic                   dr_dq_oe,
    input  logic [DQ_W-1:0]        dr_dq_in
);

    localparam int AW        = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int LANES     = 2;
    localparam int CAS_FIRST = ((T_RAC - T_RCD - 1) > T_CAC) ? (T_RAC - T_RCD - 1) : T_CAC;
    localparam int CAS_PAGE  = ((T_AA - 1) > T_CAC) ? (T_AA - 1) : T_CAC;
    localparam int MAX_A     = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_B     = (CAS_FIRST > CAS_PAGE) ? CAS_FIRST : CAS_PAGE;
    localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_MAX   = (MAX_C > T_CP) ? MAX_C : T_CP;
    localparam int CW        = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CW-1:0]    cnt;
        logic             ras_n;
        logic [LANES-1:0] cas_n;
        logic             we_n;
        logic             oe_n;
        logic [AW-1:0]    addr;
        logic             dq_oe;
        logic [DQ_W-1:0]  dq_o;
        logic             wr;
        logic [LANES-1:0] be;
        logic [DQ_W-1:0]  wdata;
        logic [AW-1:0]    col;
        logic             first;
        logic [DQ_W-1:0]  rdata;
        logic             rvalid;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        ras_n:  1'b1,
        cas_n:  '1,
        we_n:   1'b1,
        oe_n:   1'b1,
        addr:   '0,
        dq_oe:  1'b0,
        dq_o:   '0,
        wr:     1'b0,
        be:     '0,
        wdata:  '0,
        col:    '0,
        first:  1'b0,
        rdata:  '0,
        rvalid: 1'b0
    };

    seq_regs_t d, q;

    logic [ROW_W-1:0] req_row;
    logic [AW-1:0]    req_row_bus;
    logic [AW-1:0]    req_col_bus;
    logic             pg_hit;
    logic             pg_expired;
    logic             pg_open;
    logic             pg_close;
    logic             ack;
    logic [LANES-1:0] lane_strobe_n;

    edo_seq_addr #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .AW    (AW)
    ) u_addr (
        .haddr_i   (host_addr),
        .row_o     (req_row),
        .row_bus_o (req_row_bus),
        .col_bus_o (req_col_bus)
    );

    edo_seq_page #(
        .ROW_W (ROW_W),
        .LIMIT (PAGE_LIMIT)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (pg_open),
        .close_i   (pg_close),
        .row_i     (req_row),
        .hit_o     (pg_hit),
        .expired_o (pg_expired)
    );

    // Each byte lane gets its own column strobe from its enable bit.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_strobe_n[l] = ~q.be[l];
    end

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        ack      = 1'b0;
        pg_open  = 1'b0;
        pg_close = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (host_req && !refresh_grant) begin
                    ack      = 1'b1;
                    pg_open  = 1'b1;
                    d.st     = ST_ACT;
                    d.cnt    = CW'(T_RCD - 1);
                    d.ras_n  = 1'b0;
                    d.addr   = req_row_bus;
                    d.wr     = host_we;
                    d.be     = host_be;
                    d.wdata  = host_wdata;
                    d.col    = req_col_bus;
                    d.first  = 1'b1;
                end
            end

            ST_ACT: begin
                if (q.cnt == '0) begin
                    d.st    = ST_COL;
                    d.addr  = q.col;
                    d.we_n  = ~q.wr;
                    d.dq_oe = q.wr;
                    d.dq_o  = q.wdata;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end

            ST_COL: begin
                d.st    = ST_CAS;
                d.cas_n = lane_strobe_n;
                d.oe_n  = q.wr;
                d.cnt   = q.first ? CW'(CAS_FIRST - 1) : CW'(CAS_PAGE - 1);
            end

            ST_CAS: begin
                if (q.cnt == '0) begin
                    d.st    = ST_OPEN;
                    d.cas_n = '1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.cnt   = CW'(T_CP - 1);
                    if (!q.wr) begin
                        d.rdata  = dr_dq_in;
                        d.rvalid = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end

            ST_OPEN: begin
                if (pg_expired || refresh_grant) begin
                    pg_close = 1'b1;
                    d.st     = ST_PRE;
                    d.ras_n  = 1'b1;
                    d.cnt    = CW'(T_RP - 1);
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - CW'(1);
                end else if (host_req) begin
                    if (pg_hit) begin
                        ack     = 1'b1;
                        d.st    = ST_COL;
                        d.wr    = host_we;
                        d.be    = host_be;
                        d.wdata = host_wdata;
                        d.col   = req_col_bus;
                        d.first = 1'b0;
                        d.addr  = req_col_bus;
                        d.we_n  = ~host_we;
                        d.dq_oe = host_we;
                        d.dq_o  = host_wdata;
                    end else begin
                        pg_close = 1'b1;
                        d.st     = ST_PRE;
                        d.ras_n  = 1'b1;
                        d.cnt    = CW'(T_RP - 1);
                    end
                end
            end

            ST_PRE: begin
                if (q.cnt == '0) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end

            default: d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign host_ack    = ack;
    assign host_rvalid = q.rvalid;
    assign host_rdata  = q.rdata;
    assign dr_ras_n    = q.ras_n;
    assign dr_ucas_n   = q.cas_n[1];
    assign dr_lcas_n   = q.cas_n[0];
    assign dr_we_n     = q.we_n;
    assign dr_oe_n     = q.oe_n;
    assign dr_addr     = q.addr;
    assign dr_dq_out   = q.dq_o;
    assign dr_dq_oe    = q.dq_oe;

endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
    parameter int T_RP      = 4,
    parameter int RAS_BOUND = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic ucas_n,
    input logic lcas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ack,
    input logic rvalid,
    input logic ref_gnt
);

    int hi_q;
    int lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= T_RP;
            lo_q <= 0;
        end else begin
            if (ras_n) begin
                if (hi_q < T_RP) hi_q <= hi_q + 1;
                lo_q <= 0;
            end else begin
                hi_q <= 0;
                if (lo_q <= RAS_BOUND) lo_q <= lo_q + 1;
            end
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ras_n && ucas_n && lcas_n && we_n && oe_n && !dq_oe && !rvalid));

    a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n || !lcas_n) |-> !ras_n);

    a_r5_we_settled: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ucas_n) || $fell(lcas_n)) |-> (we_n == $past(we_n)));

    a_r5_write_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && dq_oe));

    a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe));

    a_r6_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    a_r9_precharge_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_q >= T_RP));

    a_r10_ras_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_q <= RAS_BOUND));

    a_r11_no_ack_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> !ack);

endmodule

bind edo_seq edo_seq_chk #(
    .T_RP      (T_RP),
    .RAS_BOUND (PAGE_LIMIT + T_RCD + CAS_FIRST + T_CP + 4)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (dr_ras_n),
    .ucas_n  (dr_ucas_n),
    .lcas_n  (dr_lcas_n),
    .we_n    (dr_we_n),
    .oe_n    (dr_oe_n),
    .dq_oe   (dr_dq_oe),
    .ack     (host_ack),
    .rvalid  (host_rvalid),
    .ref_gnt (refresh_grant)
);

// File: tb/sim_edo_seq.sv
module sim_edo_seq;

    localparam int ROW_W = 13;
    localparam int COL_W = 9;
    localparam int T_RCD = 2;
    localparam int T_RAC = 6;
    localparam int T_CAC = 2;
    localparam int T_AA  = 3;
    localparam int T_CP  = 1;
    localparam int T_RP  = 4;
    localparam int LIMIT = 30;
    // R7: strobe-low lengths from the requirement formulas
    localparam int FIRST_LEN = ((T_RAC - T_RCD - 1) > T_CAC) ? (T_RAC - T_RCD - 1) : T_CAC;
    localparam int PAGE_LEN  = ((T_AA - 1) > T_CAC) ? (T_AA - 1) : T_CAC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst_n = 1'b0;
    logic                   req = 1'b0;
    logic                   h_we = 1'b0;
    logic [ROW_W+COL_W-1:0] h_addr = '0;
    logic [1:0]             h_be = 2'b00;
    logic [15:0]            h_wd = '0;
    logic                   ref_gnt = 1'b0;
    logic                   ack, rvalid;
    logic [15:0]            rdata;
    logic                   ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [ROW_W-1:0]       dr_addr;
    logic [15:0]            dq_o;
    logic [15:0]            dq_rd = '0;

    edo_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(16), .T_RCD(T_RCD), .T_RAC(T_RAC),
        .T_CAC(T_CAC), .T_AA(T_AA), .T_CP(T_CP), .T_RP(T_RP), .PAGE_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(h_we), .host_addr(h_addr),
        .host_be(h_be), .host_wdata(h_wd), .host_ack(ack), .host_rvalid(rvalid),
        .host_rdata(rdata), .refresh_grant(ref_gnt), .dr_ras_n(ras_n), .dr_ucas_n(ucas_n),
        .dr_lcas_n(lcas_n), .dr_we_n(we_n), .dr_oe_n(oe_n), .dr_addr(dr_addr),
        .dr_dq_out(dq_o), .dr_dq_oe(dq_oe), .dr_dq_in(dq_rd)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- behavioural DRAM and host shadow ----------------
    logic [15:0] mem [int];
    logic [15:0] sh  [int];
    logic [15:0] exp_q [$];

    function automatic logic [15:0] init_word(int idx);
        return idx[15:0] ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] mem_rd(int idx);
        if (mem.exists(idx)) return mem[idx];
        return init_word(idx);
    endfunction

    function automatic logic [15:0] sh_rd(int idx);
        if (sh.exists(idx)) return sh[idx];
        return init_word(idx);
    endfunction

    bit p_ras = 1, p_u = 1, p_l = 1;
    int pm_row = 0;
    int cas_len = 0;
    bit cas_first = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int idx;
            logic [15:0] w;
            if (p_ras && !ras_n) begin
                pm_row = int'(dr_addr);
                cas_first = 1;
            end
            if ((p_u && !ucas_n) || (p_l && !lcas_n)) begin
                idx = pm_row * (1 << COL_W) + int'(dr_addr[COL_W-1:0]);
                if (!we_n) begin
                    w = mem_rd(idx);
                    if (!ucas_n) w[15:8] = dq_o[15:8];
                    if (!lcas_n) w[7:0] = dq_o[7:0];
                    mem[idx] = w;
                end else begin
                    dq_rd = mem_rd(idx);
                end
            end
            if (!ucas_n || !lcas_n) cas_len++;
            else if (cas_len != 0) begin
                // R7: strobe-low length, first access versus page hit
                chk(cas_len == (cas_first ? FIRST_LEN : PAGE_LEN), "R7 cas low cycles",
                    cas_len, cas_first ? FIRST_LEN : PAGE_LEN);
                cas_len = 0;
                cas_first = 0;
            end
            p_ras = ras_n; p_u = ucas_n; p_l = lcas_n;
        end
    end

    // ---------------- cycle reference model ----------------
    int m_ph = 0, m_left = 0, m_row = -1, m_age = 0;
    bit m_wr = 0, m_first = 0;
    logic [1:0] m_be = 0;
    logic [15:0] m_wd = 0;
    int m_col = 0;
    bit e_ras = 1, e_u = 1, e_l = 1, e_we = 1, e_oe = 1, e_dqoe = 0, e_rv = 0;
    int e_addr = 0;
    logic [15:0] e_dqo = 0;
    bit acc, expd;

    function automatic bit exp_ack();
        if (!req || ref_gnt) return 0;
        if (m_ph == 0) return 1;
        if (m_ph == 4 && m_age < LIMIT && m_left == 0 && m_row == int'(h_addr[COL_W +: ROW_W]))
            return 1;
        return 0;
    endfunction

    task automatic take_req();
        m_wr = h_we; m_be = h_be; m_wd = h_wd; m_col = int'(h_addr[COL_W-1:0]);
    endtask

    task automatic go_pre();
        m_ph = 5; e_ras = 1; m_left = T_RP - 1; m_row = -1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_row = -1; m_age = 0;
            e_ras = 1; e_u = 1; e_l = 1; e_we = 1; e_oe = 1; e_dqoe = 0; e_rv = 0; e_addr = 0;
        end else begin
            acc  = exp_ack();
            expd = (m_row >= 0) && (m_age >= LIMIT);
            e_rv = 0;
            if (m_row >= 0 && m_age < LIMIT) m_age++;
            case (m_ph)
                0: if (acc) begin
                    take_req();
                    m_ph = 1; m_left = T_RCD - 1; e_ras = 0;
                    m_row = int'(h_addr[COL_W +: ROW_W]); e_addr = m_row; m_age = 0; m_first = 1;
                end
                1: if (m_left == 0) begin
                    m_ph = 2; e_addr = m_col; e_we = !m_wr; e_dqoe = m_wr; e_dqo = m_wd;
                end else m_left--;
                2: begin
                    m_ph = 3; e_u = !m_be[1]; e_l = !m_be[0]; e_oe = m_wr;
                    m_left = (m_first ? FIRST_LEN : PAGE_LEN) - 1;
                end
                3: if (m_left == 0) begin
                    m_ph = 4; e_u = 1; e_l = 1; e_we = 1; e_oe = 1; e_dqoe = 0;
                    e_rv = !m_wr; m_left = T_CP - 1;
                end else m_left--;
                4: if (expd || ref_gnt) go_pre();
                   else if (m_left != 0) m_left--;
                   else if (req) begin
                       if (acc) begin
                           take_req();
                           m_ph = 2; m_first = 0; e_addr = m_col;
                           e_we = !m_wr; e_dqoe = m_wr; e_dqo = m_wd;
                       end else go_pre();
                   end
                5: if (m_left == 0) m_ph = 0; else m_left--;
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ras_n == e_ras, "R3/R9 row strobe", ras_n, e_ras);
            chk(ucas_n == e_u, "R4 upper strobe", ucas_n, e_u);
            chk(lcas_n == e_l, "R4 lower strobe", lcas_n, e_l);
            chk(we_n == e_we, "R5 write strobe", we_n, e_we);
            chk(oe_n == e_oe, "R6 output enable", oe_n, e_oe);
            chk(dq_oe == e_dqoe, "R5 data drive", dq_oe, e_dqoe);
            if (e_dqoe) chk(dq_o == e_dqo, "R5 write data", dq_o, e_dqo);
            chk(int'(dr_addr) == e_addr, "R2 address bus", dr_addr, e_addr);
            chk(ack == exp_ack(), "R8/R12 ack", ack, exp_ack());
            if (ref_gnt) chk(!ack, "R11 ack under refresh grant", ack, 0);
            chk(rvalid == e_rv, "R6 read valid", rvalid, e_rv);
            if (rvalid) begin
                if (exp_q.size() == 0) chk(0, "R6 unexpected read data", rdata, 0);
                else begin
                    logic [15:0] ev;
                    ev = exp_q.pop_front();
                    chk(rdata == ev, "R6 read data", rdata, ev);
                end
            end
        end
    end

    // ---------------- host driver ----------------
    task automatic host(input bit wr, input int row, input int col, input logic [1:0] be,
                        input logic [15:0] wd);
        int idx;
        logic [15:0] w;
        @(posedge clk); #1;
        req = 1; h_we = wr; h_addr = {row[ROW_W-1:0], col[COL_W-1:0]}; h_be = be; h_wd = wd;
        do @(negedge clk); while (!ack);
        idx = row * (1 << COL_W) + col;
        if (wr) begin
            w = sh_rd(idx);
            if (be[1]) w[15:8] = wd[15:8];
            if (be[0]) w[7:0] = wd[7:0];
            sh[idx] = w;
        end else begin
            exp_q.push_back(sh_rd(idx));
        end
        @(posedge clk); #1;
        req = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog expired", cycles, 150000);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ras_n && ucas_n && lcas_n, "R1 strobes idle in reset", {ras_n, ucas_n, lcas_n}, 3'b111);
        chk(we_n && oe_n && !dq_oe, "R1 we/oe/drive idle in reset", {we_n, oe_n, dq_oe}, 3'b110);
        chk(!ack && !rvalid, "R1 host outputs idle in reset", {ack, rvalid}, 2'b00);
        rst_n = 1;
        @(negedge clk);
        chk(ras_n && we_n && oe_n && !dq_oe, "R1 idle after reset", {ras_n, we_n, oe_n, dq_oe}, 4'b1110);

        // R3/R5: write from idle, then page hits R8 with lane selection R4
        host(1, 5, 3, 2'b11, 16'h1234);
        host(1, 5, 4, 2'b01, 16'h00AB);
        host(0, 5, 3, 2'b11, 16'h0);
        host(0, 5, 4, 2'b11, 16'h0);
        host(1, 5, 4, 2'b10, 16'hCD00);
        host(0, 5, 4, 2'b11, 16'h0);
        // R9: page miss forces precharge
        host(0, 9, 0, 2'b11, 16'h0);
        // R2: extreme row and column
        host(1, (1 << ROW_W) - 1, (1 << COL_W) - 1, 2'b11, 16'hFFFF);
        host(0, (1 << ROW_W) - 1, (1 << COL_W) - 1, 2'b11, 16'h0);
        host(0, 0, 0, 2'b01, 16'h0);
        // R8: burst of page hits
        for (int i = 0; i < 4; i++) host(1, 7, 10 + i, 2'b11, 16'h5A00 + 16'(i));
        for (int i = 0; i < 4; i++) host(0, 7, 10 + i, 2'b11, 16'h0);

        // R11: refresh grant with an open row and a pending request
        @(posedge clk); #1;
        ref_gnt = 1; req = 1; h_we = 0; h_addr = {13'd7, 9'd10}; h_be = 2'b11;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!ack, "R11 no ack while granted", ack, 0);
        end
        chk(ras_n, "R11 row closed under grant", ras_n, 1);
        @(posedge clk); #1;
        ref_gnt = 0; req = 0;

        // R10: open a row and leave it idle beyond the page limit
        host(1, 3, 1, 2'b11, 16'hBEEF);
        repeat (LIMIT - 12) @(negedge clk);
        chk(!ras_n, "R10 row still open before limit", ras_n, 0);
        repeat (20) @(negedge clk);
        chk(ras_n, "R10 row closed after limit", ras_n, 1);
        host(0, 3, 1, 2'b11, 16'h0);
        host(0, 7, 12, 2'b11, 16'h0);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        finish_up();
    end

endmodule